// File: doc/BRIEF.md
# Layer Trigger and Clock Source Selector

Every I/O layer in a multi-layer acquisition system uses this block to decide what starts it and what paces its samples. The layers share a four-line sync bus. Each line has a fixed role: line 0 carries the incoming trigger, line 1 the incoming or system timebase clock, line 2 triggers passed between layers, and line 3 clocks passed between layers. A 2-bit trigger selector picks one of four start sources: the software start command, the layer's own trigger pin, bus line 0 or bus line 2. A 2-bit clock selector picks the pacing source: software strobes, an internal divider, the layer's external clock pin, or the sync bus. When the sync bus is chosen, a separate bit picks line 1 or line 3.

All bus lines have a pull-up outside the block and are shared with the other layers, so a line that no layer drives reads high. The block never drives a line high. It only requests a pull-low on `bus_pull`. Pin and bus inputs pass through a synchronizer, and a rising-edge detector turns each one into a single-cycle event. Software inputs are used directly.

A controller state machine has five states. ST_IDLE waits for `arm` and moves to ST_WAIT. ST_WAIT waits for the selected trigger event and moves to ST_ALIGN; `stop` sends it back to ST_IDLE. ST_ALIGN clears the layer timestamp so that it lines up with every other layer started by the same command, then moves to ST_FIRE. ST_FIRE issues the one-cycle start pulse and moves to ST_RUN. ST_RUN passes clock-enable strobes from the selected clock source; `stop` sends it back to ST_IDLE. A layer acting as master can place its start pulse on line 2 and its clock strobes on line 3, each as a one-cycle low pulse. The pulse's release gives the receiving layers a rising edge.

Top module: `layer_sync_sel`

## Requirements
- R1: After reset, `start_pulse`, `ts_clear` and `clk_en` are low, `sample_cnt` is 0, and `bus_pull` is 0, so all four bus lines read high.
- R2: `trig_sel` encodes the start source as follows: 0 is a `sw_start` pulse, 1 is a rising edge on `ext0`, 2 is a rising edge on bus line 0, and 3 is a rising edge on bus line 2. Events from the unselected sources start nothing.
- R3: For a pin or bus trigger driven before clock edge k, `ts_clear` is high in the cycle after edge k+2 and `start_pulse` is high for exactly one cycle after edge k+3.
- R4: A `sw_start` pulse sampled at edge k in ST_WAIT with `trig_sel`=0 gives `ts_clear` after edge k and `start_pulse` after edge k+1.
- R5: `ts_clear` is high in the cycle directly before each start pulse. `ts_value` reads 0 in the start-pulse cycle and then increases by one per clock.
- R6: `clk_sel` encodes the pacing source as follows: 0 is `sw_clk`, 1 is the internal divider (one strobe every DIV cycles), 2 is a rising edge on the external clock pin (`ext1`, or `ext0` when SINGLE_LINE=1), and 3 is a rising edge on bus line 1 (`clk_line_sel`=0) or bus line 3 (`clk_line_sel`=1). Events on unselected sources produce no strobe.
- R7: `clk_en` can be high only in ST_RUN. Each event on the selected source gives exactly one `clk_en` pulse, and `sample_cnt` increases by one for each pulse.
- R8: With the sync-bus clock selected and no edges arriving, no `clk_en` pulse occurs and `sample_cnt` does not change.
- R9: With `trig_out_en` high, bus line 2 is pulled low in the start-pulse cycle. With `clk_out_en` high, bus line 3 is pulled low in each `clk_en` cycle. Lines 0 and 1 are never pulled.
- R10: `stop` returns the block to ST_IDLE, after which clock events no longer change `sample_cnt`.
- R11: A trigger event that arrives while the block is not armed (ST_IDLE) causes neither `ts_clear` nor a start pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| arm | input | 1 | Arms the layer to wait for its trigger |
| stop | input | 1 | Ends waiting or running, back to idle |
| sw_start | input | 1 | Software start command pulse |
| sw_clk | input | 1 | Software clock strobe |
| trig_sel | input | 2 | Trigger source select |
| clk_sel | input | 2 | Clock source select |
| clk_line_sel | input | 1 | Sync-bus clock line: 0 line 1, 1 line 3 |
| trig_out_en | input | 1 | Drive own start onto bus line 2 |
| clk_out_en | input | 1 | Drive own clock strobes onto bus line 3 |
| ext0 | input | 1 | Layer trigger pin |
| ext1 | input | 1 | Layer clock pin |
| bus_in | input | 4 | Resolved level of the four bus lines |
| bus_pull | output | 4 | Pull-low request per bus line |
| start_pulse | output | 1 | One-cycle layer start |
| ts_clear | output | 1 | Timestamp clear before a start |
| clk_en | output | 1 | Sample clock-enable strobe |
| ts_value | output | TS_W | Layer timestamp counter |
| sample_cnt | output | CNT_W | Number of clock-enable strobes since the start |

## Verification
The embedded assertions check the following on every cycle:
- a start pulse lasts one cycle and always follows a timestamp clear;
- the timestamp reads zero right after a clear;
- a clock-enable strobe appears only while running;
- the sample count holds whenever no strobe arrives;
- `stop` halts a running layer;
- a line-2 pull occurs only as part of a start;
- a detected edge is a single cycle.

The source encodings, the exact trigger latencies, the divider rate, the choice between bus lines 1 and 3, and the fact that unselected or pre-arm events are ignored can only be shown by the bench's sweeps. Those sweeps drive every source against every selection and count the resulting pulses.

// File: rtl/lss_pkg.sv
package lss_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WAIT,
        ST_ALIGN,
        ST_FIRE,
        ST_RUN
    } lss_state_e;

    typedef enum logic [1:0] {
        TRG_SOFT   = 2'd0,
        TRG_PIN    = 2'd1,
        TRG_BUS_IN = 2'd2,
        TRG_BUS_XL = 2'd3
    } trig_src_e;

    typedef enum logic [1:0] {
        CKS_SOFT = 2'd0,
        CKS_INT  = 2'd1,
        CKS_PIN  = 2'd2,
        CKS_BUS  = 2'd3
    } clk_src_e;

    localparam int BUS_W      = 4;
    localparam int LN_TRIG_IN = 0;
    localparam int LN_CLK_IN  = 1;
    localparam int LN_TRIG_XL = 2;
    localparam int LN_CLK_XL  = 3;

endpackage

// File: rtl/lss_edge.sv
module lss_edge #(
    parameter int STAGES   = 2,
    parameter bit IDLE_LVL = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic rise
);

    logic [STAGES-1:0] shift_q;
    logic              last_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shift_q <= {STAGES{IDLE_LVL}};
            last_q  <= IDLE_LVL;
        end else begin
            shift_q <= {shift_q[STAGES-2:0], din};
            last_q  <= shift_q[STAGES-1];
        end
    end

    assign rise = shift_q[STAGES-1] & ~last_q;

    AST_RISE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        rise |=> !rise); // R7

endmodule

// File: rtl/lss_ctrl.sv
module lss_ctrl
    import lss_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic arm,
    input  logic stop,
    input  logic trig_hit,
    output logic ts_clear,
    output logic start_pulse,
    output logic running
);

    lss_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (arm)           state_d = ST_WAIT;
            ST_WAIT:  if (stop)          state_d = ST_IDLE;
                      else if (trig_hit) state_d = ST_ALIGN;
            ST_ALIGN:                    state_d = ST_FIRE;
            ST_FIRE:                     state_d = ST_RUN;
            ST_RUN:   if (stop)          state_d = ST_IDLE;
            default:                     state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        ts_clear    = 1'b0;
        start_pulse = 1'b0;
        running     = 1'b0;
        unique case (state_q)
            ST_IDLE:  ;
            ST_WAIT:  ;
            ST_ALIGN: ts_clear    = 1'b1;
            ST_FIRE:  start_pulse = 1'b1;
            ST_RUN:   running     = 1'b1;
            default:  ;
        endcase
    end

    AST_START_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        start_pulse |=> !start_pulse); // R3
    AST_CLEAR_BEFORE_START: assert property (@(posedge clk) disable iff (!rst_n)
        start_pulse |-> $past(ts_clear)); // R5
    AST_STOP_HALTS: assert property (@(posedge clk) disable iff (!rst_n)
        (running && stop) |=> !running); // R10

endmodule

// File: rtl/lss_clkgen.sv
module lss_clkgen
    import lss_pkg::*;
#(
    parameter int DIV = 8
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       running,
    input  logic       restart,
    input  logic [1:0] sel,
    input  logic       sw_clk,
    input  logic       pin_rise,
    input  logic       bus_rise,
    output logic       clk_en
);

    localparam int DW = (DIV > 1) ? $clog2(DIV) : 1;

    logic [DW-1:0] div_q;
    logic          tick;
    logic          src_ev;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                    div_q <= '0;
        else if (restart || !running)  div_q <= '0;
        else if (div_q == DW'(DIV - 1)) div_q <= '0;
        else                           div_q <= div_q + DW'(1);
    end

    assign tick = running && (div_q == DW'(DIV - 1));

    always_comb begin
        unique case (clk_src_e'(sel))
            CKS_SOFT: src_ev = sw_clk;
            CKS_INT:  src_ev = tick;
            CKS_PIN:  src_ev = pin_rise;
            CKS_BUS:  src_ev = bus_rise;
            default:  src_ev = 1'b0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) clk_en <= 1'b0;
        else        clk_en <= running & src_ev;
    end

    AST_CLKEN_RUN: assert property (@(posedge clk) disable iff (!rst_n)
        clk_en |-> $past(running)); // R7

endmodule

// File: rtl/layer_sync_sel.sv
module layer_sync_sel
    import lss_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int DIV         = 8,
    parameter bit SINGLE_LINE = 1'b0,
    parameter int TS_W        = 16,
    parameter int CNT_W       = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             arm,
    input  logic             stop,
    input  logic             sw_start,
    input  logic             sw_clk,
    input  logic [1:0]       trig_sel,
    input  logic [1:0]       clk_sel,
    input  logic             clk_line_sel,
    input  logic             trig_out_en,
    input  logic             clk_out_en,
    input  logic             ext0,
    input  logic             ext1,
    input  logic [3:0]       bus_in,
    output logic [3:0]       bus_pull,
    output logic             start_pulse,
    output logic             ts_clear,
    output logic             clk_en,
    output logic [TS_W-1:0]  ts_value,
    output logic [CNT_W-1:0] sample_cnt
);

    logic [BUS_W-1:0] bus_rise;
    logic [1:0]       pin_rise;
    logic [1:0]       pin_raw;
    logic             trig_hit;
    logic             running;
    logic             clk_pin_ev;
    logic             clk_bus_ev;

    assign pin_raw = {ext1, ext0};

    for (genvar ln = 0; ln < BUS_W; ln++) begin : g_bus_edge
        lss_edge #(.STAGES(SYNC_STAGES), .IDLE_LVL(1'b1)) u_edge (
            .clk  (clk),
            .rst_n(rst_n),
            .din  (bus_in[ln]),
            .rise (bus_rise[ln])
        );
    end

    for (genvar pn = 0; pn < 2; pn++) begin : g_pin_edge
        lss_edge #(.STAGES(SYNC_STAGES), .IDLE_LVL(1'b0)) u_edge (
            .clk  (clk),
            .rst_n(rst_n),
            .din  (pin_raw[pn]),
            .rise (pin_rise[pn])
        );
    end

    always_comb begin
        unique case (trig_src_e'(trig_sel))
            TRG_SOFT:   trig_hit = sw_start;
            TRG_PIN:    trig_hit = pin_rise[0];
            TRG_BUS_IN: trig_hit = bus_rise[LN_TRIG_IN];
            TRG_BUS_XL: trig_hit = bus_rise[LN_TRIG_XL];
            default:    trig_hit = 1'b0;
        endcase
    end

    if (SINGLE_LINE) begin : g_clk_pin_single
        assign clk_pin_ev = pin_rise[0];
    end else begin : g_clk_pin_dual
        assign clk_pin_ev = pin_rise[1];
    end

    assign clk_bus_ev = clk_line_sel ? bus_rise[LN_CLK_XL] : bus_rise[LN_CLK_IN];

    lss_ctrl u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .arm        (arm),
        .stop       (stop),
        .trig_hit   (trig_hit),
        .ts_clear   (ts_clear),
        .start_pulse(start_pulse),
        .running    (running)
    );

    lss_clkgen #(.DIV(DIV)) u_clkgen (
        .clk     (clk),
        .rst_n   (rst_n),
        .running (running),
        .restart (ts_clear),
        .sel     (clk_sel),
        .sw_clk  (sw_clk),
        .pin_rise(clk_pin_ev),
        .bus_rise(clk_bus_ev),
        .clk_en  (clk_en)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        ts_value <= '0;
        else if (ts_clear) ts_value <= '0;
        else               ts_value <= ts_value + TS_W'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        sample_cnt <= '0;
        else if (ts_clear) sample_cnt <= '0;
        else if (clk_en)   sample_cnt <= sample_cnt + CNT_W'(1);
    end

    assign bus_pull[LN_TRIG_IN] = 1'b0;
    assign bus_pull[LN_CLK_IN]  = 1'b0;
    assign bus_pull[LN_TRIG_XL] = trig_out_en & start_pulse;
    assign bus_pull[LN_CLK_XL]  = clk_out_en & clk_en;

    AST_TS_ALIGN: assert property (@(posedge clk) disable iff (!rst_n)
        ts_clear |=> (ts_value == '0)); // R5
    AST_SAMPLES_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!clk_en && !ts_clear) |=> $stable(sample_cnt)); // R8
    AST_XL_TRIG_PULL: assert property (@(posedge clk) disable iff (!rst_n)
        bus_pull[LN_TRIG_XL] |-> $past(ts_clear)); // R9

endmodule

// File: tb/sim_layer_sync_sel.sv
`timescale 1ns/1ps
module sim_layer_sync_sel;

    localparam int DIV = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        arm = 1'b0, stop = 1'b0, sw_start = 1'b0, sw_clk = 1'b0;
    logic [1:0]  trig_sel = 2'd0, clk_sel = 2'd0;
    logic        clk_line_sel = 1'b0, trig_out_en = 1'b0, clk_out_en = 1'b0;
    logic        ext0 = 1'b0, ext1 = 1'b0;
    logic [3:0]  tb_pull = 4'h0;
    logic [3:0]  bus_in;
    logic [3:0]  bus_pull;
    logic        start_pulse, ts_clear, clk_en;
    logic [15:0] ts_value, sample_cnt;

    int n_checks = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    assign bus_in = ~(bus_pull | tb_pull);

    layer_sync_sel #(.DIV(DIV)) u0 (
        .clk(clk), .rst_n(rst_n), .arm(arm), .stop(stop),
        .sw_start(sw_start), .sw_clk(sw_clk),
        .trig_sel(trig_sel), .clk_sel(clk_sel), .clk_line_sel(clk_line_sel),
        .trig_out_en(trig_out_en), .clk_out_en(clk_out_en),
        .ext0(ext0), .ext1(ext1), .bus_in(bus_in), .bus_pull(bus_pull),
        .start_pulse(start_pulse), .ts_clear(ts_clear), .clk_en(clk_en),
        .ts_value(ts_value), .sample_cnt(sample_cnt)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic do_arm();
        arm = 1'b1; tick(); arm = 1'b0;
    endtask

    task automatic do_stop();
        stop = 1'b1; tick(); stop = 1'b0; tick();
    endtask

    // prepare a clean idle level for a trigger source
    task automatic trig_prep(input int s);
        if (s == 2) tb_pull[0] = 1'b1;
        if (s == 3) tb_pull[2] = 1'b1;
        repeat (3) tick();
    endtask

    task automatic trig_apply(input int s);
        case (s)
            0: sw_start = 1'b1;
            1: ext0 = 1'b1;
            2: tb_pull[0] = 1'b0;
            default: tb_pull[2] = 1'b0;
        endcase
    endtask

    // measure start / clear timing over 8 cycles
    task automatic trig_measure(output int first_start, output int n_start, output int first_clr);
        first_start = 0; n_start = 0; first_clr = 0;
        for (int i = 1; i <= 8; i++) begin
            tick();
            sw_start = 1'b0;
            if (start_pulse) begin
                n_start++;
                if (first_start == 0) first_start = i;
            end
            if (ts_clear && first_clr == 0) first_clr = i;
        end
        ext0 = 1'b0;
    endtask

    task automatic start_run_soft();
        trig_sel = 2'd0;
        do_arm();
        sw_start = 1'b1; tick(); sw_start = 1'b0;
        repeat (3) tick();
    endtask

    // five events on one clock source: 0 soft, 1 pin, 2 line1, 3 line3
    task automatic clk_events(input int s);
        for (int e = 0; e < 5; e++) begin
            case (s)
                0: begin sw_clk = 1'b1; tick(); sw_clk = 1'b0; repeat (3) tick(); end
                1: begin ext1 = 1'b1; repeat (3) tick(); ext1 = 1'b0; repeat (3) tick(); end
                2: begin tb_pull[1] = 1'b1; repeat (3) tick(); tb_pull[1] = 1'b0; repeat (3) tick(); end
                default: begin tb_pull[3] = 1'b1; repeat (3) tick(); tb_pull[3] = 1'b0; repeat (3) tick(); end
            endcase
        end
        repeat (4) tick();
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        int fs, ns, fc, c0, d, seen;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        tick();

        // R1 reset state
        check(!start_pulse && !ts_clear && !clk_en, "R1 pulses", {start_pulse, ts_clear, clk_en}, 0);
        check(sample_cnt == 0, "R1 sample_cnt", sample_cnt, 0);
        check(bus_pull == 4'h0 && bus_in == 4'hF, "R1 bus", bus_in, 15);

        // R11 trigger while idle
        trig_sel = 2'd0;
        trig_apply(0);
        trig_measure(fs, ns, fc);
        check(ns == 0 && fc == 0, "R11 unarmed sw_start", ns + fc, 0);
        trig_sel = 2'd1;
        trig_prep(1); trig_apply(1);
        trig_measure(fs, ns, fc);
        check(ns == 0 && fc == 0, "R11 unarmed pin", ns + fc, 0);

        // R2 R3 R4 trigger source sweep
        for (int sel = 0; sel < 4; sel++) begin
            for (int s = 0; s < 4; s++) begin
                trig_sel = 2'(sel);
                do_arm();
                trig_prep(s);
                trig_apply(s);
                trig_measure(fs, ns, fc);
                if (s == sel) begin
                    check(ns == 1, "R2 selected source starts once", ns, 1);
                    if (sel == 0) begin
                        check(fs == 2, "R4 sw start latency", fs, 2);
                        check(fc == 1, "R4 sw clear latency", fc, 1);
                    end else begin
                        check(fs == 4, "R3 hw start latency", fs, 4);
                        check(fc == 3, "R3 hw clear latency", fc, 3);
                    end
                end else begin
                    check(ns == 0, "R2 unselected source ignored", ns, 0);
                end
                do_stop();
            end
        end

        // R5 R9 timestamp alignment and line 2 drive
        trig_sel = 2'd0;
        trig_out_en = 1'b1;
        do_arm();
        repeat (5) tick();
        sw_start = 1'b1; tick(); sw_start = 1'b0;
        check(ts_clear == 1'b1, "R5 clear before start", ts_clear, 1);
        tick();
        check(start_pulse && ts_value == 0, "R5 ts zero at start", ts_value, 0);
        check(bus_in[2] == 1'b0, "R9 line2 pulled at start", bus_in[2], 0);
        check(bus_in[1:0] == 2'b11, "R9 lines 0 1 untouched", bus_in[1:0], 3);
        tick();
        check(ts_value == 1 && bus_in[2] == 1'b1, "R5 ts counts", ts_value, 1);
        trig_out_en = 1'b0;
        repeat (4) tick();

        // R6 R7 clock source sweep in run
        for (int cfg = 0; cfg < 4; cfg++) begin
            case (cfg)
                0: begin clk_sel = 2'd0; clk_line_sel = 1'b0; end
                1: begin clk_sel = 2'd2; clk_line_sel = 1'b0; end
                2: begin clk_sel = 2'd3; clk_line_sel = 1'b0; end
                default: begin clk_sel = 2'd3; clk_line_sel = 1'b1; end
            endcase
            repeat (4) tick();
            for (int s = 0; s < 4; s++) begin
                c0 = sample_cnt;
                clk_events(s);
                d = int'(sample_cnt) - c0;
                if (s == cfg) check(d == 5, "R6 R7 selected clock counts", d, 5);
                else          check(d == 0, "R6 unselected clock ignored", d, 0);
            end
        end

        // R6 internal divider
        clk_sel = 2'd1;
        repeat (6) tick();
        c0 = sample_cnt;
        repeat (40) tick();
        d = int'(sample_cnt) - c0;
        check(d == 40 / DIV, "R6 internal divide", d, 40 / DIV);

        // R8 sync clock with no edges
        clk_sel = 2'd3; clk_line_sel = 1'b0;
        repeat (4) tick();
        c0 = sample_cnt; seen = 0;
        for (int i = 0; i < 30; i++) begin
            tick();
            if (clk_en) seen++;
        end
        d = int'(sample_cnt) - c0;
        check(d == 0 && seen == 0, "R8 no edges no samples", d + seen, 0);

        // R9 line 3 drive by own clock
        clk_sel = 2'd0; clk_out_en = 1'b1;
        tick();
        sw_clk = 1'b1; tick(); sw_clk = 1'b0;
        check(clk_en == 1'b1 && bus_in[3] == 1'b0, "R9 line3 pulled with clk_en", bus_in[3], 0);
        tick();
        check(bus_in[3] == 1'b1, "R9 line3 released", bus_in[3], 1);
        clk_out_en = 1'b0;
        repeat (4) tick();

        // R10 stop ends counting
        do_stop();
        c0 = sample_cnt;
        clk_events(0);
        d = int'(sample_cnt) - c0;
        check(d == 0, "R10 stopped no samples", d, 0);

        // R7 restart after stop: count begins from zero
        start_run_soft();
        check(sample_cnt == 0, "R7 count restarts", sample_cnt, 0);
        clk_events(0);
        check(sample_cnt == 5, "R7 count after restart", sample_cnt, 5);
        do_stop();

        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule